// File: doc/BRIEF.md
# Time-Base Timer with Watchdog

This block keeps one free-running binary counter that advances on every second clock cycle. A few of its bits serve as taps. Software picks one tap for the periodic interval interrupt and, on its own, one tap for the watchdog. The interval interrupt is raised each time the chosen tap bit drops from 1 to 0. The flag stays set until software acknowledges it, and it reaches the interrupt line only while the interrupt enable is set.

The watchdog is a small 2-bit counter that steps on every rising edge of its chosen tap. If software does not clear it before a fourth rising edge arrives, the block emits a one-cycle system reset pulse and the watchdog count starts again from zero. The watchdog can be switched on by a register write but cannot be switched off again except by the block's reset input. A counter-clear input zeroes the main counter, the half-rate prescaler and the watchdog count, so a clear can never shorten the watchdog window.

By default the counter is 18 bits wide and the taps sit at bit positions 10, 12, 14 and 17. That gives interval periods of 2^12, 2^14, 2^16 and 2^19 clock cycles.

Top module: `tbt_core`

## Requirements
- R1: The main counter advances once every two clock cycles. After the edge that applies a counter clear, the interval flag for a tap at bit position k first sets on the 2^(k+2)-th rising clock edge.
- R2: Select code 0, 1, 2 and 3 chooses the tap at position TAP0, TAP1, TAP2 and TAP3. This holds for both the interval select and the watchdog select.
- R3: The interval flag stays set until an acknowledge. An acknowledge clears it on the next edge, unless a new interval event falls on that same edge, in which case the event wins.
- R4: irq_o is high exactly when the interval flag is set and the interrupt enable is 1. Setting the enable while the flag is already set raises irq_o on the next edge.
- R5: While the watchdog is disabled, sys_rst_o never rises.
- R6: With the watchdog enabled, a counter clear or a watchdog clear zeroes the watchdog count. sys_rst_o then rises on the fourth later rising edge of the selected tap bit. For tap position k, after a counter clear this is edge 7*2^(k+1).
- R7: sys_rst_o is high for exactly one cycle. Afterwards the watchdog count restarts from zero, so the next pulse follows 2^(k+4) cycles later.
- R8: Writing the watchdog enable as 1 turns the watchdog on. Writing 0 later has no effect. Only rst_ni turns it off.
- R9: A watchdog clear does not change the main counter, so the interval timing is unaffected.
- R10: A counter clear generates no interval event and no watchdog step on the edge that applies it.
- R11: After rst_ni, irq_o and sys_rst_o are low, the watchdog is disabled, and both selects and the interrupt enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_clr_i | input | 1 | Clears the counter, prescaler and watchdog count |
| ivl_wr_i | input | 1 | Write strobe for the interval select and interrupt enable |
| ivl_sel_i | input | 2 | Interval tap select code |
| ivl_ie_i | input | 1 | Interval interrupt enable value |
| irq_ack_i | input | 1 | Acknowledge that clears the interval flag |
| irq_o | output | 1 | Interval interrupt request |
| wd_wr_i | input | 1 | Write strobe for the watchdog select and enable |
| wd_sel_i | input | 2 | Watchdog tap select code |
| wd_en_i | input | 1 | Watchdog enable, set-only |
| wd_clr_i | input | 1 | Watchdog clear strobe |
| sys_rst_o | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that acknowledge, clear and write strobes are synchronous pulses driven between clock edges. They also assume that sys_rst_o is not routed back into rst_ni, so a pulse can be observed followed by the watchdog restart. The bench drives every strobe at the falling edge for exactly one cycle and keeps rst_ni separate from the reset output. Before each timing measurement it acknowledges any pending flag and applies a counter clear, so every count starts from a known zero state.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

  localparam int NUM_TAPS = 4;
  localparam int SEL_W    = 2;
  localparam int WD_W     = 2;

  typedef logic [SEL_W-1:0] tap_sel_t;

  // Bit k goes 0 -> 1 when the counter steps from cur to cur+1
  function automatic logic bit_rises(input logic [31:0] cur, input int k);
    logic [31:0] nxt;
    nxt = cur + 32'd1;
    return ~cur[k] & nxt[k];
  endfunction

  // Bit k goes 1 -> 0 when the counter steps from cur to cur+1
  function automatic logic bit_falls(input logic [31:0] cur, input int k);
    logic [31:0] nxt;
    nxt = cur + 32'd1;
    return cur[k] & ~nxt[k];
  endfunction

endpackage

// File: rtl/tbt_prescaler.sv
module tbt_prescaler #(
  parameter int CNT_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  output logic             adv_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             half_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      half_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      half_q <= ~half_q;
      if (half_q) cnt_q <= cnt_q + 1'b1;
    end
  end

  // The counter steps on this edge
  assign adv_o = half_q & ~clr_i;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tbt_tap_events.sv
module tbt_tap_events #(
  parameter int CNT_W = 18,
  parameter int TAP0  = 10,
  parameter int TAP1  = 12,
  parameter int TAP2  = 14,
  parameter int TAP3  = 17
) (
  input  logic              adv_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  tbt_pkg::tap_sel_t sel_i,
  output logic              rise_o,
  output logic              fall_o
);
  logic [tbt_pkg::NUM_TAPS-1:0] rise_v;
  logic [tbt_pkg::NUM_TAPS-1:0] fall_v;
  logic [31:0]                  cur;

  assign cur = 32'(cnt_i);

  for (genvar g = 0; g < tbt_pkg::NUM_TAPS; g++) begin : g_tap
    localparam int K = (g == 0) ? TAP0 : (g == 1) ? TAP1 : (g == 2) ? TAP2 : TAP3;
    assign rise_v[g] = adv_i & tbt_pkg::bit_rises(cur, K);
    assign fall_v[g] = adv_i & tbt_pkg::bit_falls(cur, K);
  end

  assign rise_o = rise_v[sel_i];
  assign fall_o = fall_v[sel_i];
endmodule

// File: rtl/tbt_interval.sv
module tbt_interval (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  tbt_pkg::tap_sel_t sel_i,
  input  logic              ie_i,
  input  logic              fall_i,
  input  logic              ack_i,
  output tbt_pkg::tap_sel_t sel_o,
  output logic              flag_o,
  output logic              irq_o
);
  tbt_pkg::tap_sel_t sel_q;
  logic              ie_q;
  logic              flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (wr_i) begin
        sel_q <= sel_i;
        ie_q  <= ie_i;
      end
      if (fall_i)     flag_q <= 1'b1;
      else if (ack_i) flag_q <= 1'b0;
    end
  end

  assign sel_o  = sel_q;
  assign flag_o = flag_q;
  assign irq_o  = flag_q & ie_q;
endmodule

// File: rtl/tbt_watchdog.sv
module tbt_watchdog (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  tbt_pkg::tap_sel_t sel_i,
  input  logic              en_i,
  input  logic              wd_clr_i,
  input  logic              cnt_clr_i,
  input  logic              rise_i,
  output tbt_pkg::tap_sel_t sel_o,
  output logic              en_o,
  output logic              rst_o
);
  localparam logic [tbt_pkg::WD_W-1:0] WD_MAX = '1;

  tbt_pkg::tap_sel_t         sel_q;
  logic                      en_q;
  logic [tbt_pkg::WD_W-1:0]  wcnt_q;
  logic                      rst_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      en_q   <= 1'b0;
      wcnt_q <= '0;
      rst_q  <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (wr_i) begin
        sel_q <= sel_i;
        if (en_i) en_q <= 1'b1;
      end
      if (cnt_clr_i || wd_clr_i || !en_q) begin
        wcnt_q <= '0;
      end else if (rise_i) begin
        if (wcnt_q == WD_MAX) begin
          wcnt_q <= '0;
          rst_q  <= 1'b1;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  assign sel_o = sel_q;
  assign en_o  = en_q;
  assign rst_o = rst_q;
endmodule

// File: rtl/tbt_core.sv
module tbt_core #(
  parameter int CNT_W = 18,
  parameter int TAP0  = 10,
  parameter int TAP1  = 12,
  parameter int TAP2  = 14,
  parameter int TAP3  = 17
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tb_clr_i,
  input  logic       ivl_wr_i,
  input  logic [1:0] ivl_sel_i,
  input  logic       ivl_ie_i,
  input  logic       irq_ack_i,
  output logic       irq_o,
  input  logic       wd_wr_i,
  input  logic [1:0] wd_sel_i,
  input  logic       wd_en_i,
  input  logic       wd_clr_i,
  output logic       sys_rst_o
);
  logic              adv;
  logic [CNT_W-1:0]  tb_cnt;
  tbt_pkg::tap_sel_t ivl_sel;
  tbt_pkg::tap_sel_t wd_sel;
  logic              ivl_fall;
  logic              ivl_rise_unused;
  logic              wd_rise;
  logic              wd_fall_unused;
  logic              ivl_flag;
  logic              wd_en;

  tbt_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(tb_clr_i),
    .adv_o (adv),   .cnt_o (tb_cnt)
  );

  tbt_tap_events #(.CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_ivl_tap (
    .adv_i(adv), .cnt_i(tb_cnt), .sel_i(ivl_sel),
    .rise_o(ivl_rise_unused), .fall_o(ivl_fall)
  );

  tbt_tap_events #(.CNT_W(CNT_W), .TAP0(TAP0), .TAP1(TAP1), .TAP2(TAP2), .TAP3(TAP3)) u_wd_tap (
    .adv_i(adv), .cnt_i(tb_cnt), .sel_i(wd_sel),
    .rise_o(wd_rise), .fall_o(wd_fall_unused)
  );

  tbt_interval u_ivl (
    .clk_i (clk_i),    .rst_ni(rst_ni),
    .wr_i  (ivl_wr_i), .sel_i (ivl_sel_i), .ie_i(ivl_ie_i),
    .fall_i(ivl_fall), .ack_i (irq_ack_i),
    .sel_o (ivl_sel),  .flag_o(ivl_flag),  .irq_o(irq_o)
  );

  tbt_watchdog u_wd (
    .clk_i   (clk_i),    .rst_ni   (rst_ni),
    .wr_i    (wd_wr_i),  .sel_i    (wd_sel_i), .en_i(wd_en_i),
    .wd_clr_i(wd_clr_i), .cnt_clr_i(tb_clr_i), .rise_i(wd_rise),
    .sel_o   (wd_sel),   .en_o     (wd_en),    .rst_o(sys_rst_o)
  );
endmodule

// File: rtl/tbt_core_chk.sv
module tbt_core_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tb_clr_i,
  input logic irq_ack_i,
  input logic adv,
  input logic ivl_fall,
  input logic ivl_flag,
  input logic wd_en,
  input logic irq_o,
  input logic sys_rst_o
);
  assert_adv_alternates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv |=> !adv);

  assert_flag_holds_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ivl_flag && !irq_ack_i) |=> ivl_flag);

  assert_ack_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !ivl_fall) |=> !ivl_flag);

  assert_irq_needs_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ivl_flag);

  assert_no_rst_when_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_en |=> !sys_rst_o);

  assert_rst_one_cycle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> !sys_rst_o);

  assert_enable_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_en |=> wd_en);

  assert_clear_no_event_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tb_clr_i && !ivl_flag) |=> !ivl_flag);
endmodule

bind tbt_core tbt_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tb_clr_i (tb_clr_i),
  .irq_ack_i(irq_ack_i),
  .adv      (adv),
  .ivl_fall (ivl_fall),
  .ivl_flag (ivl_flag),
  .wd_en    (wd_en),
  .irq_o    (irq_o),
  .sys_rst_o(sys_rst_o)
);

// File: tb/tbt_core_tb.sv
module tbt_core_tb;
  localparam int CNT_W = 8;
  localparam int TP0 = 1, TP1 = 3, TP2 = 5, TP3 = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tb_clr = 1'b0, ivl_wr = 1'b0, ivl_ie = 1'b0, ack = 1'b0;
  logic wd_wr = 1'b0, wd_en = 1'b0, wd_clr = 1'b0;
  logic [1:0] ivl_sel = 2'd0, wd_sel = 2'd0;
  logic irq, srst;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tbt_core #(.CNT_W(CNT_W), .TAP0(TP0), .TAP1(TP1), .TAP2(TP2), .TAP3(TP3)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .tb_clr_i(tb_clr),
    .ivl_wr_i(ivl_wr), .ivl_sel_i(ivl_sel), .ivl_ie_i(ivl_ie),
    .irq_ack_i(ack), .irq_o(irq),
    .wd_wr_i(wd_wr), .wd_sel_i(wd_sel), .wd_en_i(wd_en), .wd_clr_i(wd_clr),
    .sys_rst_o(srst)
  );

  function automatic int tap_of(input int s);
    return (s == 0) ? TP0 : (s == 1) ? TP1 : (s == 2) ? TP2 : TP3;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_pulse();
    @(negedge clk) tb_clr = 1'b1;
    @(negedge clk) tb_clr = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk) ack = 1'b1;
    @(negedge clk) ack = 1'b0;
  endtask

  task automatic wr_ivl(input int s, input bit ie);
    @(negedge clk) begin ivl_wr = 1'b1; ivl_sel = 2'(s); ivl_ie = ie; end
    @(negedge clk) ivl_wr = 1'b0;
  endtask

  task automatic wr_wd(input int s, input bit en);
    @(negedge clk) begin wd_wr = 1'b1; wd_sel = 2'(s); wd_en = en; end
    @(negedge clk) wd_wr = 1'b0;
  endtask

  // count edges until irq is seen, starting from edge index start
  task automatic wait_irq(input int start, input int lim, output int n);
    n = start;
    while (!irq && n < lim) begin @(negedge clk); n++; end
  endtask

  task automatic wait_rst(input int start, input int lim, output int n);
    n = start;
    while (!srst && n < lim) begin @(negedge clk); n++; end
  endtask

  initial begin
    int n, exp;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(irq == 1'b0 && srst == 1'b0, "R11 reset outputs", int'(irq) + int'(srst), 0);

    // R1 / R2: interval period sweep over every select code
    for (int s = 0; s < 4; s++) begin
      wr_ivl(s, 1'b1);
      clr_pulse();
      ack_pulse();
      clr_pulse();
      exp = 1 << (tap_of(s) + 2);
      wait_irq(0, 4000, n);
      check(n == exp, $sformatf("R1 R2 interval sel %0d", s), n, exp);
    end

    // R3: flag holds without ack, ack clears (sel 3, long period)
    repeat (20) @(negedge clk);
    check(irq == 1'b1, "R3 flag held", int'(irq), 1);
    ack_pulse();
    check(irq == 1'b0, "R3 ack clears", int'(irq), 0);

    // R4: enable gating
    wr_ivl(2, 1'b0);
    clr_pulse();
    repeat ((1 << (TP2 + 2)) + 2) @(negedge clk);
    check(irq == 1'b0, "R4 masked while disabled", int'(irq), 0);
    wr_ivl(2, 1'b1);
    check(irq == 1'b1, "R4 pending flag appears", int'(irq), 1);

    // R9: watchdog clear leaves the interval timing alone
    ack_pulse();
    wr_ivl(3, 1'b1);
    clr_pulse();
    repeat (99) @(negedge clk);
    wd_clr = 1'b1;
    @(negedge clk) wd_clr = 1'b0;
    wait_irq(100, 4000, n);
    exp = 1 << (TP3 + 2);
    check(n == exp, "R9 interval after wd clear", n, exp);

    // R10: repeated clears never let an event through (sel 0, period 8)
    wr_ivl(0, 1'b1);
    clr_pulse();
    ack_pulse();
    for (int i = 0; i < 12; i++) begin
      repeat (4) @(negedge clk);
      clr_pulse();
    end
    check(irq == 1'b0, "R10 no event from clears", int'(irq), 0);

    // R5: watchdog off never resets
    begin
      int seen = 0;
      clr_pulse();
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (srst) seen++;
      end
      check(seen == 0, "R5 no reset while disabled", seen, 0);
    end

    // R6 / R7 / R2: watchdog timeout sweep
    wr_ivl(0, 1'b0);
    for (int s = 0; s < 4; s++) begin
      wr_wd(s, 1'b1);
      clr_pulse();
      exp = 7 << (tap_of(s) + 1);
      wait_rst(0, 8000, n);
      check(n == exp, $sformatf("R6 R2 timeout sel %0d", s), n, exp);
      @(negedge clk);
      check(srst == 1'b0, "R7 single cycle pulse", int'(srst), 0);
      exp = 1 << (tap_of(s) + 4);
      wait_rst(1, 8000, n);
      check(n == exp, $sformatf("R7 restart period sel %0d", s), n, exp);
    end

    // R6: watchdog clear postpones expiry (sel 1, tap 3)
    wr_wd(1, 1'b1);
    clr_pulse();
    repeat (59) @(negedge clk);
    wd_clr = 1'b1;
    @(negedge clk) wd_clr = 1'b0;
    wait_rst(60, 8000, n);
    check(n == 176, "R6 expiry after wd clear", n, 176);

    // R10: frequent counter clears keep the watchdog from firing (sel 0)
    wr_wd(0, 1'b1);
    clr_pulse();
    begin
      int seen = 0;
      for (int i = 0; i < 20; i++) begin
        for (int j = 0; j < 4; j++) begin @(negedge clk); if (srst) seen++; end
        clr_pulse();
        if (srst) seen++;
      end
      check(seen == 0, "R10 clears hold watchdog", seen, 0);
    end

    // R8: writing 0 does not disable
    wr_wd(0, 1'b0);
    clr_pulse();
    exp = 7 << (TP0 + 1);
    wait_rst(0, 8000, n);
    check(n == exp, "R8 enable sticky", n, exp);

    // R8 / R11: rst_ni disables
    @(negedge clk) rst_ni = 1'b0;
    @(negedge clk) rst_ni = 1'b1;
    check(irq == 1'b0 && srst == 1'b0, "R11 outputs after reset", int'(irq) + int'(srst), 0);
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin @(negedge clk); if (srst) seen++; end
      check(seen == 0, "R8 R11 watchdog off after reset", seen, 0);
    end
    // R11: select back at 0 and enable off: flag sets at tap0 but irq stays low
    clr_pulse();
    repeat ((1 << (TP0 + 2)) + 1) @(negedge clk);
    check(irq == 1'b0, "R11 interrupt enable cleared", int'(irq), 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin @(negedge clk); cyc++; end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule